// File: doc/BRIEF.md
# Program Memory Table Access Unit

This block connects a 16-bit data-side bus to a program memory built from 24-bit words. Each access gives an 8-bit page value and a 16-bit effective address. Together they form a 24-bit program address. Bit 0 of that address picks a byte, bits 22:1 pick the word, and bit 23 chooses between the user array and a small configuration array. A low-type access reaches bits 15:0 of a word and a high-type access reaches bits 23:16. Either type can work on a whole word or on a single byte.

Table reads come straight from the array. Table writes never touch the array: they fill a row-sized write latch. A command strobe then commits the latch in one of two ways, as a single word or as a whole aligned row, and a third command erases an aligned page. Programming can only clear bits. Erase sets every bit of the page back to one. While a command is running the unit reports busy, and table accesses wait until it is done.

Top module: `ptu_table_unit`

## Requirements
- R1: The word index is bits 22:1 of {page_i, ea_i}, taken modulo MEM_WORDS. Bit 0 of ea_i is the byte select. page_i[7]=1 selects the configuration array, whose index is the word index modulo CFG_WORDS (8).
- R2: A low read in word mode returns word[15:0]. In byte mode it returns {8'h00, word[7:0]} for byte select 0 and {8'h00, word[15:8]} for byte select 1.
- R3: A high read returns {8'h00, word[23:16]} in word mode and in byte mode with byte select 0. A high byte read with byte select 1 returns 16'h0000.
- R4: A table write (we_i=1) changes only the latch entry whose index is the word index modulo ROW_WORDS:
  - A low word write sets bits 15:0 to wdata_i.
  - A low byte write puts wdata_i[7:0] into bits 7:0 (select 0) or bits 15:8 (select 1).
  - A high write, in word mode or in byte mode with select 0, puts wdata_i[7:0] into bits 23:16.
  - A high byte write with select 1 is ignored.
- R5: A read is accepted on a clock edge where req_i=1 and ready_o=1. rdata_o holds the result and rvalid_o pulses high for exactly the next cycle.
- R6: The cmd_i codes are 1 (program word), 2 (program row) and 3 (erase page). The target comes from page_i/ea_i in the strobe cycle.
- R7: Program word ANDs the latch entry into the target word. busy_o is high for exactly 1 cycle.
- R8: Program row ANDs latch entry i into word i of the row of ROW_WORDS (64) words aligned around the target. busy_o is high for ROW_WORDS cycles. After either program command, every latch entry is all ones.
- R9: Erase page sets all PAGE_WORDS (512) words of the aligned page to 24'hFFFFFF. busy_o is high for PAGE_WORDS cycles. The latch is left unchanged.
- R10: Programming never sets a bit. Programming a word twice leaves the AND of both latch values.
- R11: While busy_o=1, ready_o=0 and a pending access stalls. It is accepted on the first edge after busy_o falls.
- R12: A strobe while busy_o=1 is ignored, and so is a strobe with code 0.
- R13: After reset the configuration array reads all ones. The only command that acts on it is program word. Program row and erase page aimed at it are ignored, with no busy.
- R14: After reset, busy_o=0, ready_o=1, rvalid_o=0 and every latch entry is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Table access request |
| we_i | input | 1 | 1 = table write to latch, 0 = table read |
| hi_i | input | 1 | 1 = high-type access (bits 23:16), 0 = low-type (bits 15:0) |
| byte_i | input | 1 | 1 = byte mode, 0 = word mode |
| page_i | input | 8 | Page value, forms address bits 23:16 |
| ea_i | input | 16 | Effective address, forms address bits 15:0 |
| wdata_i | input | 16 | Table write data |
| ready_o | output | 1 | Access can be accepted this cycle |
| rdata_o | output | 16 | Table read result |
| rvalid_o | output | 1 | rdata_o holds a new result |
| cmd_go_i | input | 1 | Command strobe |
| cmd_i | input | 2 | Command code |
| busy_o | output | 1 | Command in progress |

## Verification
A read result is due one cycle after the edge that accepts it. The bench samples rvalid_o and rdata_o on the falling edge that follows that accepting edge. A command raises busy_o on the edge that takes the strobe. The bench then counts falling edges with busy_o high and expects 1, 64 or 512 of them. The array is read back only once busy_o has fallen, because the last step lands on the same edge that clears busy. The number of stalled cycles is counted from the falling edge after the strobe, so a read issued right after an erase must wait exactly 512 cycles.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_WORD  = 2'd1,
    CMD_ROW   = 2'd2,
    CMD_ERASE = 2'd3
  } cmd_e;

  localparam int unsigned PW_W = 24;
  localparam int unsigned BUS_W = 16;

  // shape a program word into a 16-bit bus result
  function automatic logic [BUS_W-1:0] fmt_read(logic [PW_W-1:0] w, logic hi, logic bm, logic bs);
    logic [BUS_W-1:0] r;
    if (!hi) begin
      if (!bm)     r = w[15:0];
      else if (bs) r = {8'h00, w[15:8]};
      else         r = {8'h00, w[7:0]};
    end else begin
      if (bm && bs) r = '0;
      else          r = {8'h00, w[23:16]};
    end
    return r;
  endfunction
endpackage

// File: rtl/ptu_latch.sv
module ptu_latch import ptu_pkg::*; #(
  parameter int unsigned ROW_WORDS = 64,
  localparam int unsigned RW = $clog2(ROW_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            hi_i,
  input  logic            byte_i,
  input  logic            bsel_i,
  input  logic [RW-1:0]   idx_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic            clr_i,
  input  logic [RW-1:0]   rd_idx_i,
  output logic [PW_W-1:0] rd_word_o
);
  logic [PW_W-1:0] q [ROW_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ROW_WORDS; i++) q[i] <= '1;
    end else if (clr_i) begin
      for (int i = 0; i < ROW_WORDS; i++) q[i] <= '1;
    end else if (wr_i) begin
      if (!hi_i) begin
        if (!byte_i)      q[idx_i][15:0]  <= wdata_i;
        else if (!bsel_i) q[idx_i][7:0]   <= wdata_i[7:0];
        else              q[idx_i][15:8]  <= wdata_i[7:0];
      end else if (!(byte_i && bsel_i)) begin
        q[idx_i][23:16] <= wdata_i[7:0];
      end
    end
  end

  assign rd_word_o = q[rd_idx_i];

  // R8
  latch_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> rd_word_o == '1);
endmodule

// File: rtl/ptu_seq.sv
module ptu_seq import ptu_pkg::*; #(
  parameter int unsigned ROW_WORDS  = 64,
  parameter int unsigned PAGE_WORDS = 512,
  parameter int unsigned AW         = 10,
  localparam int unsigned IW = $clog2(PAGE_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  cmd_e          cmd_i,
  input  logic          cfg_i,
  input  logic [AW-1:0] waddr_i,
  output logic          busy_o,
  output cmd_e          op_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] base_o,
  output logic          cfg_o,
  output logic          done_o
);
  localparam logic [AW-1:0] ROW_MASK  = ~AW'(ROW_WORDS - 1);
  localparam logic [AW-1:0] PAGE_MASK = ~AW'(PAGE_WORDS - 1);

  logic          busy_q, cfg_q;
  cmd_e          op_q;
  logic [IW-1:0] idx_q, last_q;
  logic [AW-1:0] base_q;
  logic          start;
  logic [IW-1:0] len_m1;
  logic [AW-1:0] base_d;

  assign start = go_i && !busy_q && (cmd_i != CMD_NONE) && !(cfg_i && cmd_i != CMD_WORD);

  always_comb begin
    len_m1 = '0;
    base_d = waddr_i;
    case (cmd_i)
      CMD_ROW:   begin len_m1 = IW'(ROW_WORDS - 1);  base_d = waddr_i & ROW_MASK;  end
      CMD_ERASE: begin len_m1 = IW'(PAGE_WORDS - 1); base_d = waddr_i & PAGE_MASK; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cfg_q  <= 1'b0;
      op_q   <= CMD_NONE;
      idx_q  <= '0;
      last_q <= '0;
      base_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cfg_q  <= cfg_i;
      op_q   <= cmd_i;
      idx_q  <= '0;
      last_q <= len_m1;
      base_q <= base_d;
    end else if (busy_q) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign idx_o  = idx_q;
  assign base_o = base_q;
  assign cfg_o  = cfg_q;
  assign done_o = busy_q && (idx_q == last_q);

  // R12
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o |=> $stable(op_q) && $stable(base_q));
  // R13
  cfg_bulk_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && go_i && cfg_i && (cmd_i == CMD_ROW || cmd_i == CMD_ERASE) |=> !busy_q);
endmodule

// File: rtl/ptu_array.sv
module ptu_array import ptu_pkg::*; #(
  parameter int unsigned MEM_WORDS  = 1024,
  parameter int unsigned CFG_WORDS  = 8,
  parameter int unsigned PAGE_WORDS = 512,
  localparam int unsigned AW = $clog2(MEM_WORDS),
  localparam int unsigned CW = $clog2(CFG_WORDS),
  localparam int unsigned IW = $clog2(PAGE_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  cmd_e            op_i,
  input  logic            cfg_i,
  input  logic [AW-1:0]   base_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [PW_W-1:0] latch_word_i,
  input  logic            rd_cfg_i,
  input  logic [AW-1:0]   rd_idx_i,
  output logic [PW_W-1:0] rd_word_o
);
  logic [PW_W-1:0] mem_q [MEM_WORDS];
  logic [PW_W-1:0] cfg_q [CFG_WORDS];
  logic [AW-1:0]   wa;
  logic [CW-1:0]   w_cidx, r_cidx;

  assign wa     = base_i + AW'(idx_i);
  assign w_cidx = CW'(base_i % AW'(CFG_WORDS));
  assign r_cidx = CW'(rd_idx_i % AW'(CFG_WORDS));

  always_ff @(posedge clk_i) begin
    if (step_i && !cfg_i) begin
      case (op_i)
        CMD_ERASE:         mem_q[wa] <= '1;
        CMD_ROW, CMD_WORD: mem_q[wa] <= mem_q[wa] & latch_word_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CFG_WORDS; i++) cfg_q[i] <= '1;
    end else if (step_i && cfg_i && op_i == CMD_WORD) begin
      cfg_q[w_cidx] <= cfg_q[w_cidx] & latch_word_i;
    end
  end

  assign rd_word_o = rd_cfg_i ? cfg_q[r_cidx] : mem_q[rd_idx_i];

  // R9
  erase_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !cfg_i && op_i == CMD_ERASE |=> mem_q[$past(wa)] == '1);
endmodule

// File: rtl/ptu_table_unit.sv
module ptu_table_unit import ptu_pkg::*; #(
  parameter int unsigned MEM_WORDS  = 1024,
  parameter int unsigned ROW_WORDS  = 64,
  parameter int unsigned PAGE_WORDS = 512,
  parameter int unsigned CFG_WORDS  = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        hi_i,
  input  logic        byte_i,
  input  logic [7:0]  page_i,
  input  logic [15:0] ea_i,
  input  logic [15:0] wdata_i,
  output logic        ready_o,
  output logic [15:0] rdata_o,
  output logic        rvalid_o,
  input  logic        cmd_go_i,
  input  logic [1:0]  cmd_i,
  output logic        busy_o
);
  localparam int unsigned AW = $clog2(MEM_WORDS);
  localparam int unsigned RW = $clog2(ROW_WORDS);
  localparam int unsigned IW = $clog2(PAGE_WORDS);

  logic [23:0]     prog_addr;
  logic [21:0]     word_addr;
  logic [AW-1:0]   widx;
  logic            cfg_sel, bsel, accept, busy;
  cmd_e            seq_op;
  logic [IW-1:0]   seq_idx;
  logic [AW-1:0]   seq_base;
  logic            seq_cfg, seq_done;
  logic [RW-1:0]   lat_rd_idx;
  logic [PW_W-1:0] lat_word, arr_word;
  logic [15:0]     rdata_q;
  logic            rvalid_q;

  assign prog_addr = {page_i, ea_i};
  assign word_addr = prog_addr[22:1];
  assign widx      = AW'(word_addr % 22'(MEM_WORDS));
  assign cfg_sel   = prog_addr[23];
  assign bsel      = prog_addr[0];
  assign accept    = req_i && !busy;

  ptu_seq #(.ROW_WORDS(ROW_WORDS), .PAGE_WORDS(PAGE_WORDS), .AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .go_i(cmd_go_i), .cmd_i(cmd_e'(cmd_i)), .cfg_i(cfg_sel), .waddr_i(widx),
    .busy_o(busy), .op_o(seq_op), .idx_o(seq_idx), .base_o(seq_base),
    .cfg_o(seq_cfg), .done_o(seq_done)
  );

  assign lat_rd_idx = (seq_op == CMD_WORD) ? seq_base[RW-1:0] : seq_idx[RW-1:0];

  ptu_latch #(.ROW_WORDS(ROW_WORDS)) u_latch (
    .clk_i, .rst_ni,
    .wr_i(accept && we_i), .hi_i, .byte_i, .bsel_i(bsel),
    .idx_i(widx[RW-1:0]), .wdata_i,
    .clr_i(seq_done && (seq_op == CMD_WORD || seq_op == CMD_ROW)),
    .rd_idx_i(lat_rd_idx), .rd_word_o(lat_word)
  );

  ptu_array #(.MEM_WORDS(MEM_WORDS), .CFG_WORDS(CFG_WORDS), .PAGE_WORDS(PAGE_WORDS)) u_array (
    .clk_i, .rst_ni,
    .step_i(busy), .op_i(seq_op), .cfg_i(seq_cfg), .base_i(seq_base), .idx_i(seq_idx),
    .latch_word_i(lat_word), .rd_cfg_i(cfg_sel), .rd_idx_i(widx), .rd_word_o(arr_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= accept && !we_i;
      if (accept && !we_i) rdata_q <= fmt_read(arr_word, hi_i, byte_i, bsel);
    end
  end

  assign ready_o  = !busy;
  assign busy_o   = busy;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R5
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i && ready_o));
  // R3
  phantom_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !we_i && hi_i && byte_i && bsel |=> rdata_o == 16'h0000);
  // R2
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !we_i && (byte_i || hi_i) |=> rdata_o[15:8] == 8'h00);
  // R11
  stall_no_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rvalid_o);
endmodule

// File: tb/ptu_table_unit_tb.sv
module ptu_table_unit_tb;
  localparam int MEMW = 1024, ROWW = 64, PAGEW = 512, CFGW = 8;
  localparam logic [1:0] C_NONE = 2'd0, C_WORD = 2'd1, C_ROW = 2'd2, C_ERASE = 2'd3;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, hi = 0, bm = 0, cmd_go = 0;
  logic [7:0] pg = 0;
  logic [15:0] ea = 0, wd = 0;
  logic [1:0] cmd = 0;
  logic ready, rvalid, busy;
  logic [15:0] rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [23:0] ref_mem [MEMW];
  logic [23:0] ref_cfg [CFGW];
  logic [23:0] ref_lat [ROWW];

  always #5 clk = ~clk;

  ptu_table_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .hi_i(hi), .byte_i(bm),
    .page_i(pg), .ea_i(ea), .wdata_i(wd), .ready_o(ready), .rdata_o(rdata),
    .rvalid_o(rvalid), .cmd_go_i(cmd_go), .cmd_i(cmd), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int widx(input logic [7:0] p, input logic [15:0] e);
    logic [23:0] a;
    a = {p, e};
    return int'(a[22:1]) % MEMW;
  endfunction

  function automatic logic [15:0] exp_read(input logic [23:0] w, input bit h, input bit b, input bit s);
    if (!h) return b ? (s ? {8'h0, w[15:8]} : {8'h0, w[7:0]}) : w[15:0];
    return (b && s) ? 16'h0 : {8'h0, w[23:16]};
  endfunction

  // drive at a falling edge, wait out stalls, return at the falling edge after acceptance
  task automatic tbl(input bit w, input bit h, input bit b, input logic [7:0] p,
                     input logic [15:0] e, input logic [15:0] d, output int stalls);
    req = 1; we = w; hi = h; bm = b; pg = p; ea = e; wd = d;
    stalls = 0;
    while (!ready) begin stalls++; @(negedge clk); end
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic do_write(input bit h, input bit b, input logic [7:0] p, input logic [15:0] e, input logic [15:0] d);
    int s, li;
    tbl(1, h, b, p, e, d, s);
    li = widx(p, e) % ROWW;
    if (!h) begin
      if (!b) ref_lat[li][15:0] = d;
      else if (!e[0]) ref_lat[li][7:0] = d[7:0];
      else ref_lat[li][15:8] = d[7:0];
    end else if (!(b && e[0])) ref_lat[li][23:16] = d[7:0];
  endtask

  task automatic do_read(input bit h, input bit b, input logic [7:0] p, input logic [15:0] e,
                         input string tag, output int stalls);
    logic [23:0] w;
    logic [15:0] ex;
    tbl(0, h, b, p, e, 16'h0, stalls);
    w = p[7] ? ref_cfg[widx(p, e) % CFGW] : ref_mem[widx(p, e)];
    ex = exp_read(w, h, b, e[0]);
    chk(rvalid === 1'b1, {tag, " R5 rvalid"}, 32'(rvalid), 32'd1);
    chk(rdata === ex, tag, 32'(rdata), 32'(ex));
  endtask

  task automatic ref_cmd(input logic [1:0] c, input logic [7:0] p, input logic [15:0] e);
    int w, base;
    w = widx(p, e);
    if (c == C_WORD) begin
      if (p[7]) ref_cfg[w % CFGW] &= ref_lat[w % ROWW];
      else ref_mem[w] &= ref_lat[w % ROWW];
      for (int i = 0; i < ROWW; i++) ref_lat[i] = '1;
    end else if (c == C_ROW && !p[7]) begin
      base = w - (w % ROWW);
      for (int i = 0; i < ROWW; i++) ref_mem[base + i] &= ref_lat[i];
      for (int i = 0; i < ROWW; i++) ref_lat[i] = '1;
    end else if (c == C_ERASE && !p[7]) begin
      base = w - (w % PAGEW);
      for (int i = 0; i < PAGEW; i++) ref_mem[base + i] = '1;
    end
  endtask

  task automatic pulse(input logic [1:0] c, input logic [7:0] p, input logic [15:0] e);
    cmd_go = 1; cmd = c; pg = p; ea = e;
    @(negedge clk);
    cmd_go = 0;
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [7:0] p, input logic [15:0] e,
                         input int exp_cyc, input string tag);
    int n;
    pulse(c, p, e);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == exp_cyc, tag, 32'(n), 32'(exp_cyc));
    ref_cmd(c, p, e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int s, r, wi, n;
    bit h, b, bs;
    logic [15:0] e;
    logic [7:0] p;
    void'($urandom(32'd4711));
    for (int i = 0; i < CFGW; i++) ref_cfg[i] = '1;
    for (int i = 0; i < ROWW; i++) ref_lat[i] = '1;
    for (int i = 0; i < MEMW; i++) ref_mem[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R14 reset state
    chk(busy === 1'b0, "R14 busy", 32'(busy), 0);
    chk(ready === 1'b1, "R14 ready", 32'(ready), 1);
    chk(rvalid === 1'b0, "R14 rvalid", 32'(rvalid), 0);

    // R9 erase both pages
    run_cmd(C_ERASE, 8'h00, 16'h0010, PAGEW, "R9 erase p0 cycles");
    run_cmd(C_ERASE, 8'h00, 16'h0402, PAGEW, "R9 erase p1 cycles");
    do_read(0, 0, 8'h00, 16'h0000, "R9 erased low", s);
    do_read(1, 0, 8'h00, 16'h07FE, "R9 erased high", s);
    // R14 latch ones after reset: word program leaves ones
    run_cmd(C_WORD, 8'h00, 16'h0020, 1, "R7 word cycles");
    do_read(0, 0, 8'h00, 16'h0020, "R14 latch ones low", s);
    do_read(1, 0, 8'h00, 16'h0020, "R14 latch ones high", s);

    // R2 R3 R4 directed modes on one word
    do_write(0, 0, 8'h00, 16'h0040, 16'hA5C3);
    do_write(1, 0, 8'h00, 16'h0040, 16'h3C7E);
    run_cmd(C_WORD, 8'h00, 16'h0040, 1, "R7 word cycles 2");
    do_read(0, 0, 8'h00, 16'h0040, "R2 low word", s);
    do_read(0, 1, 8'h00, 16'h0040, "R2 low byte s0", s);
    do_read(0, 1, 8'h00, 16'h0041, "R2 low byte s1", s);
    do_read(1, 0, 8'h00, 16'h0040, "R3 high word", s);
    do_read(1, 1, 8'h00, 16'h0040, "R3 high byte s0", s);
    do_read(1, 1, 8'h00, 16'h0041, "R3 phantom", s);
    // R1 page aliasing and byte select
    do_read(0, 0, 8'h15, 16'h0040, "R1 page alias", s);
    // R4 phantom write ignored
    do_write(1, 1, 8'h00, 16'h0043, 16'h0000);
    run_cmd(C_WORD, 8'h00, 16'h0042, 1, "R7 word cycles 3");
    do_read(1, 0, 8'h00, 16'h0042, "R4 phantom write ignored", s);
    // R10 bits only clear
    do_write(0, 0, 8'h00, 16'h0064, 16'h00FF);
    run_cmd(C_WORD, 8'h00, 16'h0064, 1, "R7 word cycles 4");
    do_write(0, 0, 8'h00, 16'h0064, 16'hFF00);
    run_cmd(C_WORD, 8'h00, 16'h0064, 1, "R7 word cycles 5");
    do_read(0, 0, 8'h00, 16'h0064, "R10 and of two programs", s);
    chk(rdata === 16'h0000, "R10 low zero", 32'(rdata), 0);

    // random row and word programming
    for (int it = 0; it < 30; it++) begin
      r = $urandom_range(0, MEMW / ROWW - 1);
      for (int k = 0; k < 6; k++) begin
        wi = r * ROWW + $urandom_range(0, ROWW - 1);
        bs = 1'($urandom_range(0, 1));
        e = 16'(wi * 2 + int'(bs));
        p = {1'b0, 7'($urandom_range(0, 127))};
        do_write(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), p, e, 16'($urandom));
      end
      if (it % 3 == 0) run_cmd(C_WORD, 8'h00, e, 1, "R7 random word cycles");
      else run_cmd(C_ROW, p, e, ROWW, "R8 random row cycles");
      for (int k = 0; k < 6; k++) begin
        wi = r * ROWW + $urandom_range(0, ROWW - 1);
        h = 1'($urandom_range(0, 1));
        b = 1'($urandom_range(0, 1));
        e = 16'(wi * 2 + $urandom_range(0, 1));
        do_read(h, b, {1'b0, 7'($urandom_range(0, 127))}, e, "R8 random readback", s);
      end
    end

    // R8 latch cleared after row program
    do_write(0, 0, 8'h00, 16'h0080, 16'h1234);
    run_cmd(C_ROW, 8'h00, 16'h0080, ROWW, "R8 row cycles");
    run_cmd(C_WORD, 8'h00, 16'h0080, 1, "R7 word after row");
    do_read(0, 0, 8'h00, 16'h0080, "R8 latch cleared", s);

    // R9 erase leaves latch alone
    do_write(0, 0, 8'h00, 16'h0500, 16'h0F0F);
    run_cmd(C_ERASE, 8'h00, 16'h0500, PAGEW, "R9 erase cycles");
    run_cmd(C_WORD, 8'h00, 16'h0500, 1, "R7 word after erase");
    do_read(0, 0, 8'h00, 16'h0500, "R9 latch kept", s);

    // R11 stall while erasing page 0
    pulse(C_ERASE, 8'h00, 16'h0000);
    ref_cmd(C_ERASE, 8'h00, 16'h0000);
    do_read(0, 0, 8'h00, 16'h0040, "R11 read after stall", s);
    chk(s == PAGEW, "R11 stall cycles", 32'(s), 32'(PAGEW));

    // R12 strobe while busy ignored
    pulse(C_ROW, 8'h00, 16'h0100);
    ref_cmd(C_ROW, 8'h00, 16'h0100);
    n = 0;
    while (busy) begin
      n++;
      cmd_go = (n == 5); cmd = C_ERASE; pg = 8'h00; ea = 16'h0500;
      @(negedge clk);
    end
    cmd_go = 0;
    chk(n == ROWW, "R12 row length unchanged", 32'(n), 32'(ROWW));
    @(negedge clk);
    chk(busy === 1'b0, "R12 no late start", 32'(busy), 0);
    do_read(0, 0, 8'h00, 16'h0500, "R12 page1 kept", s);
    pulse(C_NONE, 8'h00, 16'h0000);
    chk(busy === 1'b0, "R12 code0 ignored", 32'(busy), 0);

    // R13 configuration space
    do_read(0, 0, 8'h80, 16'h0004, "R13 cfg reset ones", s);
    do_write(0, 0, 8'h80, 16'h0006, 16'h1234);
    do_write(1, 0, 8'h80, 16'h0006, 16'h005A);
    run_cmd(C_WORD, 8'h80, 16'h0006, 1, "R13 cfg word cycles");
    do_read(0, 0, 8'h80, 16'h0006, "R13 cfg low", s);
    do_read(1, 0, 8'h80, 16'h0006, "R13 cfg high", s);
    do_read(0, 0, 8'h80, 16'h0016, "R1 cfg index wraps", s);
    pulse(C_ERASE, 8'h80, 16'h0006);
    chk(busy === 1'b0, "R13 cfg erase ignored", 32'(busy), 0);
    pulse(C_ROW, 8'h80, 16'h0006);
    chk(busy === 1'b0, "R13 cfg row ignored", 32'(busy), 0);
    do_read(0, 0, 8'h80, 16'h0006, "R13 cfg kept", s);
    do_read(0, 0, 8'h00, 16'h0006, "R6 user word distinct", s);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule